// File: doc/BRIEF.md
# Synchronous Serial Master/Slave Shift Engine

This block is the bit-level core of a synchronous serial port. It takes parallel words from a transmit FIFO and sends them out one bit at a time. It collects incoming serial bits into words and hands each complete word to a receive FIFO. The FIFO storage, the register interface and the clock divider are outside the block. The engine sees the FIFOs only through their empty, full, pop and push signals. It sees the divider only as a strobe input.

The same shifters serve both roles. Only the timing source changes:

- **Master role:** each divider strobe toggles the serial clock that the engine drives out. The engine also drives a frame pulse that lasts one serial period just before the first bit of every word.
- **Slave role:** the engine takes an external serial clock, frame and data. It passes all three through a two-flop synchronizer and acts on the detected edges of the synchronized clock.

Words go out most significant bit first. Data changes on the rising serial clock edge and is sampled on the falling edge. The word length is set by a 4-bit field, from 4 to 16 bits.

Top module: `ssp_shift_engine`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `sclk_out`, `frm_out`, `txd_out`, `tx_pop`, `rx_push`, `rx_data` and `overrun` are all 0.
- R2: In the master role, every word taken from the transmit FIFO appears on `txd_out` most significant bit first. Each bit is held for one serial period. `txd_out` changes only in the cycle in which `sclk_out` rises.
- R3: In the master role, `frm_out` is 1 for exactly one serial period (one falling edge of `sclk_out`) immediately before the first data bit of each word. It changes only when `sclk_out` rises.
- R4: In the master role, words are sent back to back with no idle serial period while the transmit FIFO is not empty. Once the FIFO is empty and the last bit has been sampled, `sclk_out` stays 0 and produces no more edges, even while strobes keep arriving.
- R5: In the master role, `sclk_out` changes only in the cycle after `presc_tick` was 1. It is 0 when idle, so one serial period spans two strobes.
- R6: Bits sampled on falling serial edges are assembled most significant bit first. A complete word is written to `rx_data` with its unused upper bits 0, and `rx_push` is pulsed for one cycle.
- R7: The word length is `cfg_wlen`+1 bits. Values 0, 1 and 2 all select a 4-bit word, so a 15 sent with `cfg_wlen`=0 occupies exactly 5 serial periods (frame plus 4 bits).
- R8: If `rx_full` is 1 when a word completes, the word is dropped, `rx_push` stays 0 and `overrun` becomes 1. `overrun` then stays 1 until reset.
- R9: In the slave role (`cfg_master`=0), the engine acts on the external clock, which must be at most one twelfth of the system clock. A high `frm_in` sampled on a falling edge starts a word. The following data bits are received on falling edges. The next transmit word is driven on `txd_out` starting at the rising edge after the frame. `sclk_out` and `frm_out` stay 0 in this role.
- R10: In the slave role, a word slot that starts while the transmit FIFO is empty sends all zero bits and does not pulse `tx_pop`.
- R11: `tx_pop` is pulsed once per word sent, and only while `tx_empty` is 0. The FIFO head word is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_wlen | input | 4 | Word length minus one (values below 3 mean 4 bits) |
| presc_tick | input | 1 | Divider strobe, one per half serial period (master role) |
| tx_empty | input | 1 | Transmit FIFO is empty |
| tx_data | input | 16 | Transmit FIFO head word |
| tx_pop | output | 1 | Take the head word from the transmit FIFO |
| rx_full | input | 1 | Receive FIFO is full |
| rx_push | output | 1 | `rx_data` holds a new received word |
| rx_data | output | 16 | Received word, right aligned |
| overrun | output | 1 | Sticky: a received word was dropped |
| sclk_out | output | 1 | Serial clock driven in the master role |
| frm_out | output | 1 | Frame pulse driven in the master role |
| txd_out | output | 1 | Serial transmit data |
| sclk_in | input | 1 | External serial clock (slave role) |
| frm_in | input | 1 | External frame pulse (slave role) |
| rxd_in | input | 1 | Serial receive data |

## Verification
The assertions watch the edge rules on every cycle:
- in the master role, data and frame move only on a rising serial edge, and the serial clock moves only after a strobe;
- a pop never meets an empty FIFO and a push never meets a full one;
- the overrun flag never falls;
- nothing leaves the master-only outputs in the slave role.

Some behaviour only the bench's scenarios can show, because it spans whole words:
- that words arrive intact and MSB first through the loopback and through an emulated external master;
- that the frame takes exactly one period;
- that back-to-back words leave no gap and the clock then stops;
- that short length codes collapse to four bits;
- that an empty FIFO in the slave role yields zeros.

// File: rtl/ssp_pkg.sv
// Package: shared types of the serial shift engine.
// Assumes: consumers import it; nothing here holds state.
package ssp_pkg;

    // Serial clock edge events as seen in the system clock domain.
    typedef struct packed {
        logic rise;
        logic fall;
    } sedge_t;

    // Role encoding of the cfg_master input.
    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

endpackage

// File: rtl/ssp_clk_ctrl.sv
// Module: serial timing source.
// In the master role it toggles its own serial clock on divider strobes. It
// only starts a rising edge when the transmitter has more to send, and it
// always completes a falling edge. In the slave role it synchronizes the
// external clock, frame and data through SYNC flops and emits edge events.
// Assumes: SYNC >= 2 and an external clock slower than sysclk/12.
module ssp_clk_ctrl
    import ssp_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  role_e  role,
    input  logic   presc_tick,
    input  logic   want_rise,
    input  logic   sclk_in,
    input  logic   frm_in,
    input  logic   rxd_in,
    output logic   sclk_q,
    output sedge_t ev,
    output logic   frm_s,
    output logic   rxd_s
);
    logic [SYNC-1:0] sck_sh;
    logic [SYNC-1:0] frm_sh;
    logic [SYNC-1:0] rxd_sh;
    logic            sck_d;
    logic            is_m;

    assign is_m  = (role == ROLE_MASTER);
    assign frm_s = frm_sh[SYNC-1];
    assign rxd_s = rxd_sh[SYNC-1];

    // Edge event selection: divider-driven in master role, synchronized edges in slave role.
    always_comb begin
        if (is_m) begin
            ev.rise = presc_tick & ~sclk_q & want_rise;
            ev.fall = presc_tick & sclk_q;
        end else begin
            ev.rise = sck_sh[SYNC-1] & ~sck_d;
            ev.fall = ~sck_sh[SYNC-1] & sck_d;
        end
    end

    // Synchronizer chains for the three external serial inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sh <= '0;
            frm_sh <= '0;
            rxd_sh <= '0;
            sck_d  <= 1'b0;
        end else begin
            sck_sh <= {sck_sh[SYNC-2:0], sclk_in};
            frm_sh <= {frm_sh[SYNC-2:0], frm_in};
            rxd_sh <= {rxd_sh[SYNC-2:0], rxd_in};
            sck_d  <= sck_sh[SYNC-1];
        end
    end

    // Master serial clock register, held low in the slave role.
    always_ff @(posedge clk) begin
        if (!rst_n || !is_m) begin
            sclk_q <= 1'b0;
        end else if (ev.rise) begin
            sclk_q <= 1'b1;
        end else if (ev.fall) begin
            sclk_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ssp_tx.sv
// Module: transmit shifter.
// On each rising event it either opens a word slot or shifts out the next bit,
// MSB first:
// - master role: a word slot opens with a one-period frame and the pop;
// - slave role: a frame seen by the receiver arms the shifter, and the next
//   rising event pops and drives the MSB, or zeros if the FIFO is empty.
// Assumes: msb (length-1) is stable while a word is in flight.
module ssp_tx
    import ssp_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  role_e         role,
    input  sedge_t        ev,
    input  logic [IW-1:0] msb,
    input  logic          tx_empty,
    input  logic [DW-1:0] tx_data,
    input  logic          slv_start,
    output logic          tx_pop,
    output logic          txd,
    output logic          frm,
    output logic          more
);
    localparam int CW = IW + 1;

    logic [DW-1:0] sreg;
    logic [CW-1:0] left;
    logic          armed;
    logic          is_m;
    logic          drained;
    logic [CW-1:0] word_bits;
    logic [DW-1:0] slv_word;

    assign is_m      = (role == ROLE_MASTER);
    assign drained   = (left == '0);
    assign word_bits = {1'b0, msb} + CW'(1);
    assign slv_word  = tx_empty ? '0 : tx_data;
    assign tx_pop    = ev.rise & (is_m ? drained : (armed & ~tx_empty));
    assign more      = ~drained | ~tx_empty;

    // Shift register, bit counter, frame and slave arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg  <= '0;
            left  <= '0;
            armed <= 1'b0;
            txd   <= 1'b0;
            frm   <= 1'b0;
        end else begin
            if (!is_m && slv_start) begin
                armed <= 1'b1;
            end
            if (ev.rise) begin
                if (is_m && drained) begin
                    frm  <= 1'b1;
                    txd  <= 1'b0;
                    sreg <= tx_data;
                    left <= word_bits;
                end else if (!is_m && armed) begin
                    frm   <= 1'b0;
                    txd   <= slv_word[msb];
                    sreg  <= slv_word << 1;
                    left  <= {1'b0, msb};
                    armed <= 1'b0;
                end else if (!drained) begin
                    frm  <= 1'b0;
                    txd  <= sreg[msb];
                    sreg <= sreg << 1;
                    left <= left - CW'(1);
                end else begin
                    frm <= 1'b0;
                    txd <= 1'b0;
                end
            end
            if (!is_m) begin
                frm <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ssp_rx.sv
// Module: receive shifter.
// On each falling event a high frame bit restarts word collection. Otherwise
// the data bit is shifted in MSB first. When the programmed count is reached,
// the word is pushed, or dropped with a sticky overrun if the FIFO is full.
// Assumes: msb is stable while a word is in flight.
module ssp_rx #(
    parameter int DW = 16,
    parameter int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall,
    input  logic          frm_bit,
    input  logic          rxd_bit,
    input  logic [IW-1:0] msb,
    input  logic          rx_full,
    output logic          rx_push,
    output logic [DW-1:0] rx_data,
    output logic          overrun,
    output logic          frame_seen
);
    localparam int CW = IW + 1;

    logic [DW-1:0] acc;
    logic [CW-1:0] got;
    logic          active;
    logic [DW-1:0] acc_nx;
    logic [CW-1:0] got_nx;
    logic          done;

    assign acc_nx     = {acc[DW-2:0], rxd_bit};
    assign got_nx     = got + CW'(1);
    assign done       = (got_nx == ({1'b0, msb} + CW'(1)));
    assign frame_seen = fall & frm_bit;

    // Word assembly, push pulse and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            got     <= '0;
            active  <= 1'b0;
            rx_push <= 1'b0;
            rx_data <= '0;
            overrun <= 1'b0;
        end else begin
            rx_push <= 1'b0;
            if (fall) begin
                if (frm_bit) begin
                    active <= 1'b1;
                    got    <= '0;
                    acc    <= '0;
                end else if (active) begin
                    acc <= acc_nx;
                    got <= got_nx;
                    if (done) begin
                        active <= 1'b0;
                        if (rx_full) begin
                            overrun <= 1'b1;
                        end else begin
                            rx_push <= 1'b1;
                            rx_data <= acc_nx;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ssp_shift_engine.sv
// Module: serial shift engine top.
// It joins the timing source, the transmit shifter and the receive shifter,
// and clamps the word-length code. Frame and data for the receiver come from
// the engine's own outputs in the master role and from the synchronized
// external pins in the slave role.
// Assumes: configuration changes only while no word is in flight.
module ssp_shift_engine
    import ssp_pkg::*;
#(
    parameter int DW   = 16,
    parameter int SYNC = 2,
    localparam int IW  = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_master,
    input  logic [IW-1:0] cfg_wlen,
    input  logic          presc_tick,
    input  logic          tx_empty,
    input  logic [DW-1:0] tx_data,
    output logic          tx_pop,
    input  logic          rx_full,
    output logic          rx_push,
    output logic [DW-1:0] rx_data,
    output logic          overrun,
    output logic          sclk_out,
    output logic          frm_out,
    output logic          txd_out,
    input  logic          sclk_in,
    input  logic          frm_in,
    input  logic          rxd_in
);
    role_e         role;
    sedge_t        ev;
    logic [IW-1:0] msb;
    logic          want_rise;
    logic          frm_s;
    logic          rxd_s;
    logic          frame_seen;
    logic          frm_bit;
    logic          rxd_bit;

    assign role    = cfg_master ? ROLE_MASTER : ROLE_SLAVE;
    assign msb     = (cfg_wlen < IW'(3)) ? IW'(3) : cfg_wlen;
    assign frm_bit = cfg_master ? frm_out : frm_s;
    assign rxd_bit = cfg_master ? rxd_in  : rxd_s;

    ssp_clk_ctrl #(.SYNC(SYNC)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .role      (role),
        .presc_tick(presc_tick),
        .want_rise (want_rise),
        .sclk_in   (sclk_in),
        .frm_in    (frm_in),
        .rxd_in    (rxd_in),
        .sclk_q    (sclk_out),
        .ev        (ev),
        .frm_s     (frm_s),
        .rxd_s     (rxd_s)
    );

    ssp_tx #(.DW(DW), .IW(IW)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .role     (role),
        .ev       (ev),
        .msb      (msb),
        .tx_empty (tx_empty),
        .tx_data  (tx_data),
        .slv_start(frame_seen & ~cfg_master),
        .tx_pop   (tx_pop),
        .txd      (txd_out),
        .frm      (frm_out),
        .more     (want_rise)
    );

    ssp_rx #(.DW(DW), .IW(IW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall      (ev.fall),
        .frm_bit   (frm_bit),
        .rxd_bit   (rxd_bit),
        .msb       (msb),
        .rx_full   (rx_full),
        .rx_push   (rx_push),
        .rx_data   (rx_data),
        .overrun   (overrun),
        .frame_seen(frame_seen)
    );

endmodule

// File: rtl/ssp_shift_engine_chk.sv
// Module: property checker for the serial shift engine, bound to the top.
// Assumes: it observes top-level ports only.
module ssp_shift_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_master,
    input logic presc_tick,
    input logic tx_empty,
    input logic tx_pop,
    input logic rx_full,
    input logic rx_push,
    input logic overrun,
    input logic sclk_out,
    input logic frm_out,
    input logic txd_out
);
    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty); // R11

    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $past(!rx_full)); // R8

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R8

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_master && !$past(cfg_master)) |-> (!sclk_out && !frm_out)); // R9

    AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && $past(cfg_master) && !$stable(sclk_out)) |-> $past(presc_tick)); // R5

    AST_TXD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && $past(cfg_master) && !$stable(txd_out)) |-> $rose(sclk_out)); // R2

    AST_FRM_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && $past(cfg_master) && !$stable(frm_out)) |-> $rose(sclk_out)); // R3

endmodule

bind ssp_shift_engine ssp_shift_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_master(cfg_master),
    .presc_tick(presc_tick),
    .tx_empty  (tx_empty),
    .tx_pop    (tx_pop),
    .rx_full   (rx_full),
    .rx_push   (rx_push),
    .overrun   (overrun),
    .sclk_out  (sclk_out),
    .frm_out   (frm_out),
    .txd_out   (txd_out)
);

// File: tb/ssp_shift_engine_bench.sv
// Bench: master loopback and emulated external master, random plus directed.
module ssp_shift_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b1;
    logic [3:0]  cfg_wlen = 4'd7;
    logic        presc_tick = 1'b0;
    logic        tx_empty = 1'b1;
    logic [15:0] tx_data = '0;
    logic        tx_pop;
    logic        rx_full = 1'b0;
    logic        rx_push;
    logic [15:0] rx_data;
    logic        overrun;
    logic        sclk_out, frm_out, txd_out;
    logic        sclk_in = 1'b0, frm_in = 1'b0, rxd_in_s = 1'b0;
    logic        rxd_in;

    assign rxd_in = cfg_master ? txd_out : rxd_in_s;

    ssp_shift_engine u_ssp_shift_engine (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_wlen(cfg_wlen),
        .presc_tick(presc_tick), .tx_empty(tx_empty), .tx_data(tx_data),
        .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
        .overrun(overrun), .sclk_out(sclk_out), .frm_out(frm_out), .txd_out(txd_out),
        .sclk_in(sclk_in), .frm_in(frm_in), .rxd_in(rxd_in)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [15:0] txq[$], rxq[$], monq[$];
    bit pop_pend = 0;
    int n_pop = 0, n_fall = 0, n_frm = 0, cyc = 0, last_fall = 0;
    int min_gap = 0, max_gap = 0, cur_len = 8;
    bit prev_sclk = 0, mon_act = 0;
    int mon_bits = 0;
    logic [15:0] mon_acc = '0;
    int tick_per = 3, tick_ctr = 0;
    bit tick_on = 0;
    logic [15:0] wbuf[4];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [3:0] code);
        return (code < 4'd3) ? 4 : int'(code) + 1;
    endfunction

    function automatic logic [15:0] mask_of(input int len);
        logic [31:0] m = (32'h1 << len) - 32'h1;
        return m[15:0];
    endfunction

    // Divider strobe model, driven away from the active edge.
    always begin
        @(posedge clk);
        #2;
        if (tick_on) begin
            tick_ctr   = (tick_ctr + 1 >= tick_per) ? 0 : tick_ctr + 1;
            presc_tick = (tick_ctr == 0);
        end else begin
            tick_ctr   = 0;
            presc_tick = 1'b0;
        end
    end

    // FIFO models and master-side serial decoder, sampled on the falling clock.
    always @(negedge clk) begin
        cyc++;
        if (pop_pend && txq.size() > 0) void'(txq.pop_front());
        pop_pend = tx_pop;
        if (tx_pop) n_pop++;
        tx_empty = (txq.size() == 0);
        tx_data  = tx_empty ? 16'h0 : txq[0];
        if (rx_push) rxq.push_back(rx_data);
        if (cfg_master && prev_sclk && !sclk_out) begin
            if (n_fall > 0) begin
                if (cyc - last_fall < min_gap) min_gap = cyc - last_fall;
                if (cyc - last_fall > max_gap) max_gap = cyc - last_fall;
            end
            last_fall = cyc;
            n_fall++;
            if (frm_out) begin
                n_frm++;
                mon_act = 1; mon_bits = 0; mon_acc = '0;
            end else if (mon_act) begin
                mon_acc = {mon_acc[14:0], txd_out};
                mon_bits++;
                if (mon_bits == cur_len) begin
                    monq.push_back(mon_acc);
                    mon_act = 0;
                end
            end
        end
        prev_sclk = sclk_out;
    end

    task automatic do_reset();
        @(posedge clk); #2;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk(sclk_out == 0 && frm_out == 0 && txd_out == 0 && tx_pop == 0 && rx_push == 0 &&
            rx_data == 0 && overrun == 0, "R1 outputs in reset",
            {sclk_out, frm_out, txd_out, tx_pop, rx_push, overrun, rx_data}, 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk(sclk_out == 0 && frm_out == 0 && rx_push == 0 && overrun == 0, "R1 after release",
            {sclk_out, frm_out, rx_push, overrun}, 32'h0);
    endtask

    // Master loopback run of nw words from wbuf.
    task automatic run_master(input logic [3:0] code, input int per, input int nw, input bit expect_push);
        int len = exp_len(code);
        int snap;
        cfg_wlen = code; cur_len = len;
        rxq.delete(); monq.delete();
        n_fall = 0; n_frm = 0; min_gap = 1000000; max_gap = 0; mon_act = 0;
        for (int i = 0; i < nw; i++) txq.push_back(wbuf[i]);
        repeat (2) @(posedge clk);
        tick_per = per; tick_on = 1;
        while (txq.size() != 0) @(posedge clk);
        repeat (2 * per * (len + 3) + 10) @(posedge clk);
        snap = n_fall;
        repeat (10 * per) @(posedge clk);
        #2;
        chk(n_fall == snap && sclk_out == 0, "R4 clock stopped when empty", n_fall, snap);
        tick_on = 0;
        repeat (4) @(posedge clk);
        #2;
        chk(monq.size() == nw, "R2 word count on line", monq.size(), nw);
        for (int i = 0; i < nw && i < monq.size(); i++)
            chk(monq[i] == (wbuf[i] & mask_of(len)), "R2 MSB-first serial word", monq[i], wbuf[i] & mask_of(len));
        chk(n_frm == nw, "R3 one frame per word", n_frm, nw);
        chk(n_fall == nw * (len + 1), "R7 serial periods frame plus bits", n_fall, nw * (len + 1));
        if (nw > 1) chk(max_gap == 2 * per && min_gap == 2 * per, "R4 no gap between words", max_gap, 2 * per);
        chk(nw == 1 || min_gap == 2 * per, "R5 two strobes per period", min_gap, 2 * per);
        if (expect_push) begin
            chk(rxq.size() == nw, "R6 received word count", rxq.size(), nw);
            for (int i = 0; i < nw && i < rxq.size(); i++)
                chk(rxq[i] == (wbuf[i] & mask_of(len)), "R6 loopback word", rxq[i], wbuf[i] & mask_of(len));
        end else begin
            chk(rxq.size() == 0, "R8 no push while full", rxq.size(), 0);
        end
    endtask

    task automatic half_sclk();
        repeat (12) @(posedge clk);
        #2;
    endtask

    // Emulated external master: one frame plus len bits; captures slave output.
    task automatic run_slave(input logic [3:0] code, input logic [15:0] win, input bit has_tx, input logic [15:0] wtx);
        int len = exp_len(code);
        int pops0;
        logic [15:0] got = '0;
        logic [15:0] exp_tx;
        cfg_wlen = code; cur_len = len;
        rxq.delete();
        if (has_tx) txq.push_back(wtx);
        repeat (2) @(posedge clk);
        #2;
        pops0 = n_pop;
        sclk_in = 1; frm_in = 1; rxd_in_s = 0;
        half_sclk();
        sclk_in = 0;
        half_sclk();
        for (int i = len - 1; i >= 0; i--) begin
            sclk_in = 1; frm_in = 0; rxd_in_s = win[i];
            half_sclk();
            got[i] = txd_out;
            chk(sclk_out == 0 && frm_out == 0, "R9 master outputs quiet", {sclk_out, frm_out}, 0);
            sclk_in = 0;
            half_sclk();
        end
        repeat (6) @(posedge clk);
        #2;
        exp_tx = has_tx ? (wtx & mask_of(len)) : 16'h0;
        chk(got == exp_tx, has_tx ? "R9 slave transmit word" : "R10 zeros when empty", got, exp_tx);
        chk(rxq.size() == 1 && rxq[0] == (win & mask_of(len)), "R9 slave receive word",
            rxq.size() > 0 ? rxq[0] : 16'hDEAD, win & mask_of(len));
        chk(n_pop - pops0 == (has_tx ? 1 : 0), has_tx ? "R11 one pop per word" : "R10 no pop when empty",
            n_pop - pops0, has_tx ? 1 : 0);
        while (txq.size() != 0) void'(txq.pop_front());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        do_reset();

        // Directed: two back-to-back 8-bit words (R2, R3, R4, R6).
        wbuf[0] = 16'h00A5; wbuf[1] = 16'h003C;
        run_master(4'd7, 3, 2, 1);
        // Directed: short codes collapse to 4 bits (R7).
        wbuf[0] = 16'hFFFF;
        run_master(4'd0, 3, 1, 1);
        wbuf[0] = 16'h1239; wbuf[1] = 16'hFFF6;
        run_master(4'd2, 4, 2, 1);
        wbuf[0] = 16'h0005;
        run_master(4'd3, 3, 1, 1);
        // Directed: full 16-bit words.
        wbuf[0] = 16'hBEEF; wbuf[1] = 16'h8001; wbuf[2] = 16'h7FFE;
        run_master(4'd15, 5, 3, 1);

        // Random master bursts.
        for (int b = 0; b < 24; b++) begin
            int nw = 1 + int'($urandom_range(3));
            for (int i = 0; i < nw; i++) wbuf[i] = 16'($urandom());
            run_master(4'($urandom_range(15)), 3 + int'($urandom_range(3)), nw, 1);
        end

        // Overrun: full FIFO drops the word, flag sticks (R8).
        rx_full = 1;
        wbuf[0] = 16'h0F0F;
        run_master(4'd7, 3, 1, 0);
        chk(overrun == 1, "R8 overrun set", overrun, 1);
        rx_full = 0;
        wbuf[0] = 16'h0033;
        run_master(4'd7, 3, 1, 1);
        chk(overrun == 1, "R8 overrun sticky", overrun, 1);

        // Slave role.
        cfg_master = 0;
        do_reset();
        run_slave(4'd7, 16'h00C3, 1, 16'h005A);
        run_slave(4'd1, 16'h000A, 1, 16'hFFF5);
        run_slave(4'd15, 16'hA55A, 0, 16'h0);
        for (int k = 0; k < 14; k++)
            run_slave(4'($urandom_range(15)), 16'($urandom()), (k % 4) != 3, 16'($urandom()));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule